// File: doc/BRIEF.md
# Barrel Shift Execution Unit

This block is the shift stage of a small integer pipeline that uses 16-bit instruction words. The decoder hands it an 8-bit major opcode, the destination operand Ri, the source operand Rj, the 4-bit immediate field of the instruction and the current condition flags. One clock edge later it returns the shifted value, the new flag word and a write strobe for Ri.

There are three shift kinds: left with zero fill, right with zero fill, and right with sign fill. Each kind has three opcodes, and the opcode alone picks where the shift amount comes from: the low bits of Rj, the immediate (0 to 15), or the immediate plus 16 (16 to 31). A 5-bit immediate written by a programmer is split across the last two forms, so together they reach every amount from 0 to 31. The overflow flag is never changed by a shift.

Flag word layout used on `flags_in` and `flags_out`: bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.

Top module: `shift_exec_unit`

## Requirements
- R1: Opcodes 0xB6 (amount from Rj), 0xB4 (amount = imm) and 0xB5 (amount = imm + 16) shift Ri left and fill the vacated low bits with zeros.
- R2: Opcodes 0xB2 (Rj), 0xB0 (imm) and 0xB1 (imm + 16) shift Ri right and fill the vacated high bits with zeros.
- R3: Opcodes 0xBA (Rj), 0xB8 (imm) and 0xB9 (imm + 16) shift Ri right and fill the vacated high bits with copies of Ri bit 31.
- R4: A register-sourced shift uses only bits 4:0 of Rj; bits 31:5 of Rj have no effect on the result or the flags.
- R5: C (flags_out bit 0) is the last bit shifted out: Ri[32-n] for a left shift by n, Ri[n-1] for a right shift by n, with n from 1 to 31.
- R6: A shift by zero returns Ri unchanged and clears C.
- R7: After a shift, N (bit 3) equals result bit 31 and Z (bit 2) is 1 exactly when the result is all zeros.
- R8: After a shift, V (bit 1) equals V on flags_in.
- R9: When op_valid is low or the opcode is not one of the nine shift opcodes, ri_we is 0, result is 0 and flags_out equals flags_in.
- R10: Every output reflects the inputs sampled at the previous rising clock edge; a shift takes exactly one cycle and asserts ri_we for that cycle.
- R11: While rst_n is low, result, flags_out and ri_we are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Major opcode of the instruction |
| ri_val | input | 32 | Value of the destination register Ri |
| rj_val | input | 32 | Value of the source register Rj |
| imm_u4 | input | 4 | Immediate field of the instruction |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| result | output | 32 | Shifted value to write to Ri |
| flags_out | output | 4 | Updated flags {N,Z,V,C} |
| ri_we | output | 1 | Write strobe for Ri |

## Verification
The bench aims at the amount edges: zero, where a design that reads a stale carry would leave C set or alter Ri, and 31 through the plus-16 opcodes, where a wrong offset would shift by 15 or wrap. It drives Rj values with junk in the upper bits, which a design decoding too many amount bits would turn into over-long shifts, and negative Ri values under both right shifts, which a mixed-up fill would betray in the top bits and in N. Opcodes next to the shift group (0xB3, 0xB7, 0xBB, 0xA4) and held-off cycles catch a decoder that writes Ri or corrupts flags when it should stay idle, and a V input set to 1 exposes any path that clears the overflow flag.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

   typedef enum logic [1:0] {
      SK_LEFT  = 2'd0,
      SK_RLOG  = 2'd1,
      SK_RARI  = 2'd2
   } shift_kind_e;

   typedef enum logic [1:0] {
      AS_REG    = 2'd0,
      AS_IMM_LO = 2'd1,
      AS_IMM_HI = 2'd2
   } amt_src_e;

   typedef struct packed {
      logic        hit;
      shift_kind_e kind;
      amt_src_e    src;
   } shift_ctl_t;

   localparam int FLG_C = 0;
   localparam int FLG_V = 1;
   localparam int FLG_Z = 2;
   localparam int FLG_N = 3;
   localparam int FLG_W = 4;

endpackage

// File: rtl/shift_op_decode.sv
module shift_op_decode
   import shift_unit_pkg::*;
#(
   parameter int         OPC_W     = 8,
   parameter logic [3:0] OPC_GROUP = 4'hB
) (
   input  logic [OPC_W-1:0] opcode,
   output shift_ctl_t       ctl
);
   localparam int GRP_LSB = OPC_W - 4;

   if (OPC_W != 8) begin : g_bad_opc_w
      $error("shift_op_decode: OPC_W must be 8");
   end

   logic       group_ok;
   logic [1:0] kind_bits;
   logic [1:0] src_bits;

   assign group_ok  = (opcode[OPC_W-1:GRP_LSB] == OPC_GROUP);
   assign kind_bits = opcode[3:2];
   assign src_bits  = opcode[1:0];

   always_comb begin
      ctl.hit  = group_ok;
      ctl.kind = SK_LEFT;
      ctl.src  = AS_REG;
      unique case (kind_bits)
         2'b00:   ctl.kind = SK_RLOG;
         2'b01:   ctl.kind = SK_LEFT;
         2'b10:   ctl.kind = SK_RARI;
         default: ctl.hit  = 1'b0;
      endcase
      unique case (src_bits)
         2'b00:   ctl.src = AS_IMM_LO;
         2'b01:   ctl.src = AS_IMM_HI;
         2'b10:   ctl.src = AS_REG;
         default: ctl.hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/shift_amount_sel.sv
module shift_amount_sel
   import shift_unit_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 4,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  amt_src_e         src,
   input  logic [AMT_W-1:0] rj_low,
   input  logic [IMM_W-1:0] imm,
   output logic [AMT_W-1:0] amount
);
   localparam logic [AMT_W-1:0] HI_OFFSET = AMT_W'(1 << IMM_W);

   if (IMM_W >= AMT_W) begin : g_bad_imm_w
      $error("shift_amount_sel: IMM_W must be below the amount width");
   end

   logic [AMT_W-1:0] imm_ext;
   assign imm_ext = AMT_W'(imm);

   always_comb begin
      unique case (src)
         AS_IMM_LO: amount = imm_ext;
         AS_IMM_HI: amount = imm_ext + HI_OFFSET;
         default:   amount = rj_low;
      endcase
   end
endmodule

// File: rtl/shift_barrel_core.sv
module shift_barrel_core
   import shift_unit_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W),
   localparam int EXT_W = DATA_W + 1
) (
   input  shift_kind_e       kind,
   input  logic [DATA_W-1:0] operand,
   input  logic [AMT_W-1:0]  amount,
   output logic [DATA_W-1:0] shifted,
   output logic              carry
);
   if (DATA_W != (1 << AMT_W)) begin : g_bad_data_w
      $error("shift_barrel_core: DATA_W must be a power of two");
   end

   logic              go_left;
   logic              fill;
   logic [DATA_W-1:0] operand_rev;
   logic [DATA_W-1:0] staged_rev;
   logic [DATA_W-1:0] staged;
   logic [EXT_W-1:0]  lane [0:AMT_W];

   assign go_left = (kind == SK_LEFT);
   assign fill    = (kind == SK_RARI) & operand[DATA_W-1];

   for (genvar b = 0; b < DATA_W; b++) begin : g_rev_in
      assign operand_rev[b] = operand[DATA_W-1-b];
   end

   // extra lane bit below the data catches the last bit shifted out
   assign lane[0] = {(go_left ? operand_rev : operand), 1'b0};

   for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      assign lane[k+1] = amount[k] ? {{STEP{fill}}, lane[k][EXT_W-1:STEP]}
                                   : lane[k];
   end

   assign staged = lane[AMT_W][EXT_W-1:1];
   assign carry  = lane[AMT_W][0];

   for (genvar b = 0; b < DATA_W; b++) begin : g_rev_out
      assign staged_rev[b] = staged[DATA_W-1-b];
   end

   assign shifted = go_left ? staged_rev : staged;
endmodule

// File: rtl/shift_flag_gen.sv
module shift_flag_gen
   import shift_unit_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic             write,
   input  logic [DATA_W-1:0] value,
   input  logic             carry,
   input  logic [FLG_W-1:0] flags_in,
   output logic [FLG_W-1:0] flags_next
);
   always_comb begin
      flags_next = flags_in;
      if (write) begin
         flags_next[FLG_N] = value[DATA_W-1];
         flags_next[FLG_Z] = ~|value;
         flags_next[FLG_C] = carry;
      end
   end
endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
   import shift_unit_pkg::*;
#(
   parameter int         DATA_W    = 32,
   parameter int         IMM_W     = 4,
   parameter int         OPC_W     = 8,
   parameter logic [3:0] OPC_GROUP = 4'hB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [DATA_W-1:0] ri_val,
   input  logic [DATA_W-1:0] rj_val,
   input  logic [IMM_W-1:0]  imm_u4,
   input  logic [3:0]        flags_in,
   output logic [DATA_W-1:0] result,
   output logic [3:0]        flags_out,
   output logic              ri_we
);
   localparam int AMT_W = $clog2(DATA_W);

   if (DATA_W < 4) begin : g_bad_width
      $error("shift_exec_unit: DATA_W too small");
   end

   shift_ctl_t        ctl;
   logic              do_write;
   logic [AMT_W-1:0]  amount;
   logic [DATA_W-1:0] shifted;
   logic              carry;
   logic [FLG_W-1:0]  flags_next;
   logic              rj_high_unused;

   assign rj_high_unused = ^rj_val[DATA_W-1:AMT_W];

   shift_op_decode #(.OPC_W(OPC_W), .OPC_GROUP(OPC_GROUP)) i_decode (
      .opcode (opcode),
      .ctl    (ctl)
   );

   assign do_write = op_valid & ctl.hit;

   shift_amount_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_amount (
      .src    (ctl.src),
      .rj_low (rj_val[AMT_W-1:0]),
      .imm    (imm_u4),
      .amount (amount)
   );

   shift_barrel_core #(.DATA_W(DATA_W)) i_core (
      .kind    (ctl.kind),
      .operand (ri_val),
      .amount  (amount),
      .shifted (shifted),
      .carry   (carry)
   );

   shift_flag_gen #(.DATA_W(DATA_W)) i_flags (
      .write      (do_write),
      .value      (shifted),
      .carry      (carry),
      .flags_in   (flags_in),
      .flags_next (flags_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result    <= '0;
         flags_out <= '0;
         ri_we     <= 1'b0;
      end else begin
         result    <= do_write ? shifted : '0;
         flags_out <= flags_next;
         ri_we     <= do_write;
      end
   end

   AST_V_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> flags_out[FLG_V] == $past(flags_in[FLG_V])); // R8

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !do_write |=> !ri_we && result == '0 && flags_out == $past(flags_in)); // R9

   AST_ZERO_AMOUNT: assert property (@(posedge clk) disable iff (!rst_n)
      do_write && amount == '0 |=> result == $past(ri_val) && !flags_out[FLG_C]); // R6

   AST_N_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      ri_we |-> flags_out[FLG_N] == result[DATA_W-1]); // R7

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      do_write |=> ri_we); // R10
endmodule

// File: tb/test_shift_exec_unit.sv
module test_shift_exec_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [31:0] ri_val = '0;
   logic [31:0] rj_val = '0;
   logic [3:0]  imm_u4 = '0;
   logic [3:0]  flags_in = '0;
   logic [31:0] result;
   logic [3:0]  flags_out;
   logic        ri_we;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #2.5 clk = ~clk;

   shift_exec_unit i_shift_exec_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
      .ri_val(ri_val), .rj_val(rj_val), .imm_u4(imm_u4), .flags_in(flags_in),
      .result(result), .flags_out(flags_out), .ri_we(ri_we)
   );

   logic [31:0] exp_res = '0;
   logic [3:0]  exp_flg = '0;
   logic        exp_we  = 1'b0;
   string       exp_tag = "R11";

   task automatic model(input logic v, input logic [7:0] op, input logic [31:0] ri,
                        input logic [31:0] rj, input logic [3:0] imm, input logic [3:0] fl);
      int amt;
      int kind;
      logic [31:0] r;
      logic c;
      kind = -1;
      amt  = 0;
      if (v && op[7:4] == 4'hB && op[1:0] != 2'b11 && op[3:2] != 2'b11) begin
         kind = op[3:2];
         if (op[1:0] == 2'b10) amt = int'(rj % 32);
         else if (op[1:0] == 2'b00) amt = int'(imm);
         else amt = int'(imm) + 16;
      end
      if (kind < 0) begin
         exp_we = 0; exp_res = 0; exp_flg = fl; exp_tag = "R9";
         return;
      end
      r = ri; c = 0;
      for (int i = 0; i < amt; i++) begin
         if (kind == 1) begin c = r[31]; r = r << 1; end
         else begin c = r[0]; r = {(kind == 2) ? r[31] : 1'b0, r[31:1]}; end
      end
      exp_we = 1; exp_res = r;
      exp_flg = {r[31], (r == 0), fl[1], c};
      if (amt == 0) exp_tag = "R6";
      else if (op[1:0] == 2'b10 && rj[31:5] != 0) exp_tag = "R4";
      else if (kind == 1) exp_tag = "R1/R5/R7/R8/R10";
      else if (kind == 0) exp_tag = "R2/R5/R7/R8/R10";
      else exp_tag = "R3/R5/R7/R8/R10";
   endtask

   task automatic compare();
      n_tests++;
      if (result !== exp_res || flags_out !== exp_flg || ri_we !== exp_we) begin
         n_fail++;
         $display("FAIL %s: got res=%h flg=%b we=%b, expected res=%h flg=%b we=%b",
                  exp_tag, result, flags_out, ri_we, exp_res, exp_flg, exp_we);
      end
   endtask

   task automatic step(input logic v, input logic [7:0] op, input logic [31:0] ri,
                       input logic [31:0] rj, input logic [3:0] imm, input logic [3:0] fl);
      @(negedge clk);
      compare();
      op_valid = v; opcode = op; ri_val = ri; rj_val = rj; imm_u4 = imm; flags_in = fl;
      model(v, op, ri, rj, imm, fl);
   endtask

   localparam logic [7:0] OPS [0:12] = '{8'hB6, 8'hB4, 8'hB5, 8'hB2, 8'hB0, 8'hB1,
                                        8'hBA, 8'hB8, 8'hB9, 8'hB3, 8'hB7, 8'hBB, 8'hA4};

   initial begin
      // R11: reset state, inputs active during reset
      op_valid = 1; opcode = 8'hB4; ri_val = 32'hFFFF_FFFF; imm_u4 = 4'd3; flags_in = 4'hF;
      repeat (3) begin @(negedge clk); compare(); end
      rst_n = 1;
      model(1, 8'hB4, 32'hFFFF_FFFF, 0, 4'd3, 4'hF);
      // directed corners
      step(1, 8'hB6, 32'h1234_5678, 32'h0000_0000, 0, 4'b0001); // R6 reg zero
      step(1, 8'hB0, 32'h8000_0001, 0, 4'd0, 4'b1011);           // R6 imm zero
      step(1, 8'hB4, 32'h8000_0001, 0, 4'd1, 4'b0000);           // R1 R5 C=1
      step(1, 8'hB5, 32'h0000_0001, 0, 4'd15, 4'b0010);          // R1 shift 31
      step(1, 8'hB1, 32'h8000_0000, 0, 4'd15, 4'b0010);          // R2 shift 31
      step(1, 8'hB9, 32'h8000_0000, 0, 4'd15, 4'b0000);          // R3 shift 31
      step(1, 8'hB8, 32'hF000_000F, 0, 4'd4, 4'b0010);           // R3 sign fill
      step(1, 8'hB0, 32'hF000_000F, 0, 4'd4, 4'b0000);           // R2 zero fill
      step(1, 8'hB2, 32'h8000_0100, 32'hFFFF_FFE8, 0, 4'b0010);  // R4 amt 8
      step(1, 8'hBA, 32'h8000_0100, 32'h7FFF_FF20, 0, 4'b0000);  // R4 amt 0
      step(1, 8'hB6, 32'h0000_0003, 32'hABCD_EF3F, 0, 4'b0010);  // R4 amt 31
      step(1, 8'hB4, 32'h0000_0000, 0, 4'd5, 4'b0010);           // R7 Z
      step(1, 8'hB3, 32'h1111_1111, 0, 4'd2, 4'b1010);           // R9
      step(1, 8'hB7, 32'h1111_1111, 0, 4'd2, 4'b0101);           // R9
      step(1, 8'hBB, 32'h1111_1111, 0, 4'd2, 4'b1111);           // R9
      step(1, 8'hA4, 32'h1111_1111, 0, 4'd2, 4'b0110);           // R9
      step(0, 8'hB4, 32'h1111_1111, 0, 4'd2, 4'b1001);           // R9 idle
      step(1, 8'hB4, 32'h4000_0000, 0, 4'd1, 4'b0000);           // R10 back to back
      // pseudo-random mix
      for (int n = 0; n < 600; n++) begin
         logic [7:0] op;
         op = OPS[$urandom % 13];
         step(($urandom % 8) != 0, op, $urandom, $urandom, 4'($urandom), 4'($urandom));
      end
      @(negedge clk); compare();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #50000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule